// File: doc/BRIEF.md
# Video Dot Timing Event Sequencer

This block is the timing heart of a tile-based video processor. It walks a raster of 341 dots per line and 262 lines per frame, so one frame lasts 89,342 clock cycles. At every dot it decodes a small set of single-cycle action strobes that tell the rest of the video pipeline what to do on that dot. The strobes cover background tile fetches (name-table, attribute, pattern low plane, pattern high plane), the scroll-address updates (horizontal and vertical increment, horizontal and vertical copy from the temporary address), and the two sprite phases (evaluation and tile fetch).

Lines 0 to 239 are the visible lines and line 261 is the pre-render line; both are rendering lines. Lines 240 to 260 carry no strobes. A vertical-blank flag is set when line 241 begins and cleared when the pre-render line begins. An interrupt request follows that flag whenever the interrupt enable is high. When rendering is switched off, every strobe is held low while the counters and the blank flag keep running. The block performs no memory access and produces no pixels; it only says when those things happen.

Top module: `vdt_sequencer`

## Requirements
- R1: After reset `dot` and `line` are 0. `dot` counts up by one each cycle from 0 to 340 and then wraps to 0; at that wrap `line` advances by one, and it wraps from 261 to 0.
- R2: On rendering lines, in dots 1–256 and 321–336, the background fetch strobes fire by the value of `dot mod 8`: 1 gives `ntFetch`, 3 gives `atFetch`, 5 gives `patLoFetch`, and 7 gives `patHiFetch`. Each strobe lasts one cycle. At most one of the four is high at a time.
- R3: `hInc` is high on rendering lines at every dot that is a multiple of 8 from 8 to 256, and at dots 328 and 336.
- R4: `vInc` is high at dot 256 of each rendering line, and it is high together with `hInc`. `hCopy` is high at dot 257 of each rendering line.
- R5: `vCopy` is high on dots 280 to 304 of line 261 only.
- R6: `sprEval` is high on dots 65 to 256 of visible lines (0–239). `sprFetch` is high on dots 257 to 320 of every rendering line.
- R7: `vblank` is 0 after reset. It goes high in the cycle that shows line 241 dot 1 and goes low in the cycle that shows line 261 dot 1.
- R8: `nmiReq` is high exactly when `vblank` and `nmiEn` are both high. A change of `nmiEn` shows on `nmiReq` in the same cycle.
- R9: While `renderEn` is low, all ten strobes are low. The counters and `vblank` are not affected.
- R10: On lines 240 to 260 all strobes stay low, even with `renderEn` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous reset, active low |
| renderEn | input | 1 | Rendering enable; gates all strobes |
| nmiEn | input | 1 | Interrupt enable for the vertical-blank request |
| ntFetch | output | 1 | Name-table fetch strobe |
| atFetch | output | 1 | Attribute fetch strobe |
| patLoFetch | output | 1 | Pattern low-plane fetch strobe |
| patHiFetch | output | 1 | Pattern high-plane fetch strobe |
| hInc | output | 1 | Horizontal scroll increment |
| vInc | output | 1 | Vertical scroll increment |
| hCopy | output | 1 | Copy horizontal bits from the temporary address |
| vCopy | output | 1 | Copy vertical bits from the temporary address |
| sprEval | output | 1 | Sprite evaluation window |
| sprFetch | output | 1 | Sprite tile fetch window |
| dot | output | 9 | Current dot within the line |
| line | output | 9 | Current scanline |
| vblank | output | 1 | Vertical-blank flag |
| nmiReq | output | 1 | Vertical-blank interrupt request |

## Verification
Dot 256 is the one place where two scroll actions share a cycle: the last horizontal increment of the visible fetch run and the vertical increment. The very next dot brings the horizontal copy together with the first sprite-fetch cycle. A full frame is run with rendering on, and a reference model built from the dot windows above predicts every strobe on every dot. Both coincidences are therefore judged bit by bit against independent predictions. A second pass turns `renderEn` off for whole lines and for part of a line, and turns `nmiEn` off and back on inside the blank interval. This confirms that the gating drops only the strobes, and that the interrupt request tracks the enable in the same cycle.

// File: rtl/vdt_pkg.sv
package vdt_pkg;

  // Dot positions inside a line that shape the action windows.
  localparam int FETCH_FIRST     = 1;
  localparam int FETCH_LAST      = 256;
  localparam int PREFETCH_FIRST  = 321;
  localparam int PREFETCH_LAST   = 336;
  localparam int VINC_DOT        = 256;
  localparam int HCOPY_DOT       = 257;
  localparam int SPR_EVAL_FIRST  = 65;
  localparam int SPR_EVAL_LAST   = 256;
  localparam int SPR_FETCH_FIRST = 257;
  localparam int SPR_FETCH_LAST  = 320;
  localparam int VCOPY_FIRST     = 280;
  localparam int VCOPY_LAST      = 304;

  // Phase inside an 8-dot group, counted from the first dot of the group.
  localparam logic [2:0] PH_NT  = 3'd0;
  localparam logic [2:0] PH_AT  = 3'd2;
  localparam logic [2:0] PH_LO  = 3'd4;
  localparam logic [2:0] PH_HI  = 3'd6;
  localparam logic [2:0] PH_INC = 3'd7;

  typedef struct packed {
    logic ntFetch;
    logic atFetch;
    logic patLoFetch;
    logic patHiFetch;
    logic hInc;
    logic vInc;
    logic hCopy;
    logic vCopy;
    logic sprEval;
    logic sprFetch;
  } dotAction_t;

  // Strobes from control to the frame datapath.
  typedef struct packed {
    logic setVblank;
    logic clrVblank;
  } frameCtl_t;

endpackage

// File: rtl/vdt_counters.sv
module vdt_counters
  import vdt_pkg::*;
#(
  parameter int DOT_COUNT  = 341,
  parameter int LINE_COUNT = 262,
  parameter int DW         = 9,
  parameter int LW         = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  frameCtl_t     ctl,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          vblank
);

  localparam logic [DW-1:0] LAST_DOT  = DW'(DOT_COUNT - 1);
  localparam logic [LW-1:0] LAST_LINE = LW'(LINE_COUNT - 1);

  logic lineEnd;
  assign lineEnd = (dot == LAST_DOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dot <= '0;
    end else if (lineEnd) begin
      dot <= '0;
    end else begin
      dot <= dot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      line <= '0;
    end else if (lineEnd) begin
      line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vblank <= 1'b0;
    end else if (ctl.setVblank) begin
      vblank <= 1'b1;
    end else if (ctl.clrVblank) begin
      vblank <= 1'b0;
    end
  end

endmodule

// File: rtl/vdt_decode.sv
module vdt_decode
  import vdt_pkg::*;
#(
  parameter int LINE_COUNT = 262,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int DW         = 9,
  parameter int LW         = 9
) (
  input  logic [DW-1:0] dot,
  input  logic [LW-1:0] line,
  input  logic          renderEn,
  output dotAction_t    act,
  output frameCtl_t     ctl
);

  localparam int PRE_LINE = LINE_COUNT - 1;

  int         d;
  int         l;
  logic [2:0] phase;
  logic       visLine;
  logic       preLine;
  logic       rendLine;
  logic       inFetch;
  logic       fetchOn;
  logic       lineOn;

  always_comb begin
    d        = int'(dot);
    l        = int'(line);
    phase    = 3'(d - FETCH_FIRST);
    visLine  = (l < VIS_LINES);
    preLine  = (l == PRE_LINE);
    rendLine = visLine || preLine;
    inFetch  = ((d >= FETCH_FIRST) && (d <= FETCH_LAST)) ||
               ((d >= PREFETCH_FIRST) && (d <= PREFETCH_LAST));
    lineOn   = renderEn && rendLine;
    fetchOn  = lineOn && inFetch;
  end

  always_comb begin
    act            = '0;
    act.ntFetch    = fetchOn && (phase == PH_NT);
    act.atFetch    = fetchOn && (phase == PH_AT);
    act.patLoFetch = fetchOn && (phase == PH_LO);
    act.patHiFetch = fetchOn && (phase == PH_HI);
    act.hInc       = fetchOn && (phase == PH_INC);
    act.vInc       = lineOn && (d == VINC_DOT);
    act.hCopy      = lineOn && (d == HCOPY_DOT);
    act.vCopy      = renderEn && preLine && (d >= VCOPY_FIRST) && (d <= VCOPY_LAST);
    act.sprEval    = renderEn && visLine && (d >= SPR_EVAL_FIRST) && (d <= SPR_EVAL_LAST);
    act.sprFetch   = lineOn && (d >= SPR_FETCH_FIRST) && (d <= SPR_FETCH_LAST);
  end

  always_comb begin
    ctl.setVblank = (l == VBL_LINE) && (d == 0);
    ctl.clrVblank = preLine && (d == 0);
  end

endmodule

// File: rtl/vdt_sequencer.sv
module vdt_sequencer
  import vdt_pkg::*;
#(
  parameter int DOT_COUNT  = 341,
  parameter int LINE_COUNT = 262,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int DW         = $clog2(DOT_COUNT),
  parameter int LW         = $clog2(LINE_COUNT)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          renderEn,
  input  logic          nmiEn,
  output logic          ntFetch,
  output logic          atFetch,
  output logic          patLoFetch,
  output logic          patHiFetch,
  output logic          hInc,
  output logic          vInc,
  output logic          hCopy,
  output logic          vCopy,
  output logic          sprEval,
  output logic          sprFetch,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          vblank,
  output logic          nmiReq
);

  dotAction_t act;
  frameCtl_t  ctl;

  vdt_counters #(
    .DOT_COUNT (DOT_COUNT),
    .LINE_COUNT(LINE_COUNT),
    .DW        (DW),
    .LW        (LW)
  ) u_counters (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .dot   (dot),
    .line  (line),
    .vblank(vblank)
  );

  vdt_decode #(
    .LINE_COUNT(LINE_COUNT),
    .VIS_LINES (VIS_LINES),
    .VBL_LINE  (VBL_LINE),
    .DW        (DW),
    .LW        (LW)
  ) u_decode (
    .dot     (dot),
    .line    (line),
    .renderEn(renderEn),
    .act     (act),
    .ctl     (ctl)
  );

  assign ntFetch    = act.ntFetch;
  assign atFetch    = act.atFetch;
  assign patLoFetch = act.patLoFetch;
  assign patHiFetch = act.patHiFetch;
  assign hInc       = act.hInc;
  assign vInc       = act.vInc;
  assign hCopy      = act.hCopy;
  assign vCopy      = act.vCopy;
  assign sprEval    = act.sprEval;
  assign sprFetch   = act.sprFetch;
  assign nmiReq     = vblank && nmiEn;

endmodule

// File: rtl/vdt_sequencer_chk.sv
module vdt_sequencer_chk #(
  parameter int DOT_COUNT  = 341,
  parameter int LINE_COUNT = 262,
  parameter int VIS_LINES  = 240,
  parameter int VBL_LINE   = 241,
  parameter int DW         = 9,
  parameter int LW         = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          renderEn,
  input logic          nmiEn,
  input logic          ntFetch,
  input logic          atFetch,
  input logic          patLoFetch,
  input logic          patHiFetch,
  input logic          hInc,
  input logic          vInc,
  input logic          hCopy,
  input logic          vCopy,
  input logic          sprEval,
  input logic          sprFetch,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          vblank,
  input logic          nmiReq
);

  localparam int PRE_LINE = LINE_COUNT - 1;

  logic [9:0] allStrobes;
  assign allStrobes = {ntFetch, atFetch, patLoFetch, patHiFetch, hInc,
                       vInc, hCopy, vCopy, sprEval, sprFetch};

  p_dot_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dot) < DOT_COUNT - 1) |=> (int'(dot) == int'($past(dot)) + 1));

  p_dot_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (int'(dot) == DOT_COUNT - 1) |=> (dot == '0) && (line != $past(line)));

  p_fetch_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ntFetch, atFetch, patLoFetch, patHiFetch}));

  p_vinc_pairs_hinc_r4: assert property (@(posedge clk) disable iff (!rstN)
    vInc |-> hInc && (int'(dot) == 256));

  p_hcopy_after_vinc_r4: assert property (@(posedge clk) disable iff (!rstN)
    vInc |=> hCopy);

  p_vcopy_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    vCopy |-> (int'(line) == PRE_LINE));

  p_spr_eval_visible_r6: assert property (@(posedge clk) disable iff (!rstN)
    sprEval |-> (int'(line) < VIS_LINES) && !sprFetch);

  p_vblank_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vblank) |-> (int'(line) == VBL_LINE) && (int'(dot) == 1));

  p_vblank_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vblank) |-> (int'(line) == PRE_LINE) && (int'(dot) == 1));

  p_nmi_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> vblank && nmiEn);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !renderEn |-> (allStrobes == '0));

  p_quiet_blank_lines_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(line) >= VIS_LINES) && (int'(line) < PRE_LINE)) |-> (allStrobes == '0));

endmodule

bind vdt_sequencer vdt_sequencer_chk #(
  .DOT_COUNT (DOT_COUNT),
  .LINE_COUNT(LINE_COUNT),
  .VIS_LINES (VIS_LINES),
  .VBL_LINE  (VBL_LINE),
  .DW        (DW),
  .LW        (LW)
) u_chk (.*);

// File: tb/vdt_sequencer_test.sv
module vdt_sequencer_test;

  typedef struct packed {
    logic [8:0] d;
    logic [8:0] l;
    logic       ren;
    logic [9:0] act;
    logic       vb;
    logic       nmi;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       renderEn = 1'b0;
  logic       nmiEn = 1'b0;
  logic       ntFetch, atFetch, patLoFetch, patHiFetch, hInc, vInc;
  logic       hCopy, vCopy, sprEval, sprFetch, vblank, nmiReq;
  logic [8:0] dot;
  logic [8:0] line;

  int compared = 0;
  int mismatched = 0;
  int printed = 0;
  bit done = 1'b0;

  expItem_t expQ[$];
  event     sampleEv;

  // Bench reference state.
  int mDot = 0;
  int mLine = 0;
  int mFrame = 0;
  bit mVbl = 1'b0;

  always #5 clk = ~clk;

  vdt_sequencer uut (
    .clk(clk), .rstN(rstN), .renderEn(renderEn), .nmiEn(nmiEn),
    .ntFetch(ntFetch), .atFetch(atFetch), .patLoFetch(patLoFetch),
    .patHiFetch(patHiFetch), .hInc(hInc), .vInc(vInc), .hCopy(hCopy),
    .vCopy(vCopy), .sprEval(sprEval), .sprFetch(sprFetch),
    .dot(dot), .line(line), .vblank(vblank), .nmiReq(nmiReq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      if (printed < 20) begin
        printed++;
        $display("FAIL %s %s at line %0d dot %0d: actual=%0d expected=%0d",
                 req, what, mLine, mDot, act, exp);
      end
    end
  endtask

  // Expected strobes, written from the dot windows of R2..R6 and R10.
  function automatic logic [9:0] expectActs(input int d, input int l, input bit ren);
    bit vis, rend, win;
    logic [9:0] a;
    vis  = (l <= 239);
    rend = vis || (l == 261);
    win  = (d >= 1 && d <= 256) || (d >= 321 && d <= 336);
    a    = '0;
    if (ren && rend) begin
      a[9] = win && (d % 8 == 1);                 // R2 name-table
      a[8] = win && (d % 8 == 3);                 // R2 attribute
      a[7] = win && (d % 8 == 5);                 // R2 pattern low
      a[6] = win && (d % 8 == 7);                 // R2 pattern high
      a[5] = win && (d % 8 == 0);                 // R3 horizontal increment
      a[4] = (d == 256);                          // R4 vertical increment
      a[3] = (d == 257);                          // R4 horizontal copy
      a[2] = (l == 261) && d >= 280 && d <= 304;  // R5 vertical copy
      a[1] = vis && d >= 65 && d <= 256;          // R6 sprite evaluation
      a[0] = d >= 257 && d <= 320;                // R6 sprite fetch
    end
    return a;
  endfunction

  // Driver: choose inputs for this dot and queue the expected outputs.
  task automatic driveDot();
    expItem_t it;
    bit ren, ne;
    ren = 1'b1;
    ne  = 1'b1;
    if (mFrame == 0) begin
      if (mLine >= 240 && mLine <= 242) ne = 1'b0;
      if (mLine == 250 && mDot < 50) ne = 1'b0;
    end else begin
      if (mLine < 10) ren = 1'b0;
      if (mLine == 15 && mDot >= 100 && mDot <= 200) ren = 1'b0;
      if (mLine == 20 && mDot >= 250 && mDot <= 260) ren = 1'b0;
    end
    renderEn = ren;
    nmiEn    = ne;
    #1;
    it.d   = 9'(mDot);
    it.l   = 9'(mLine);
    it.ren = ren;
    it.act = expectActs(mDot, mLine, ren);
    it.vb  = mVbl;
    it.nmi = mVbl && ne;
    expQ.push_back(it);
    -> sampleEv;
  endtask

  task automatic advanceModel();
    if (mLine == 241 && mDot == 0) mVbl = 1'b1;
    else if (mLine == 261 && mDot == 0) mVbl = 1'b0;
    if (mDot == 340) begin
      mDot = 0;
      if (mLine == 261) begin
        mLine = 0;
        mFrame++;
      end else begin
        mLine++;
      end
    end else begin
      mDot++;
    end
  endtask

  // Monitor: pop and compare each queued item.
  initial begin
    forever begin
      expItem_t e;
      logic [9:0] got;
      string tagS;
      @(sampleEv);
      e = expQ.pop_front();
      got = {ntFetch, atFetch, patLoFetch, patHiFetch, hInc, vInc,
             hCopy, vCopy, sprEval, sprFetch};
      check("R1", "dot", int'(dot), int'(e.d));
      check("R1", "line", int'(line), int'(e.l));
      if (!e.ren) tagS = "R9";
      else if (e.l >= 240 && e.l <= 260) tagS = "R10";
      else tagS = "";
      check(tagS == "" ? "R2" : tagS, "bg fetch strobes", int'(got[9:6]), int'(e.act[9:6]));
      check(tagS == "" ? "R3" : tagS, "hInc", int'(got[5]), int'(e.act[5]));
      check(tagS == "" ? "R4" : tagS, "vInc/hCopy", int'(got[4:3]), int'(e.act[4:3]));
      check(tagS == "" ? "R5" : tagS, "vCopy", int'(got[2]), int'(e.act[2]));
      check(tagS == "" ? "R6" : tagS, "sprite strobes", int'(got[1:0]), int'(e.act[1:0]));
      check("R7", "vblank", int'(vblank), int'(e.vb));
      check("R8", "nmiReq", int'(nmiReq), int'(e.nmi));
    end
  end

  // Watchdog.
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state is covered by the first compared dot (0, 0, vblank low).
    while (!(mFrame == 1 && mLine == 30)) begin
      driveDot();
      @(posedge clk);
      advanceModel();
      @(negedge clk);
    end
    done = 1'b1;
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule